// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wake-Up

This block receives asynchronous serial characters on a shared multidrop line. It runs from a system clock and advances its bit timing only on an oversampling enable that pulses sixteen times per bit period. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. Each bit is judged by a majority vote of three samples taken at the middle of its cell. Good characters appear on a data output together with a one-cycle valid strobe. Bad stop bits raise a framing-error pulse. An all-zero frame with a bad stop bit also raises a break pulse.

Software can put the receiver to sleep so that characters meant for other stations cause no data-ready strobe. The receiver wakes by itself through one of two methods, chosen by a control input. In idle-line mode it wakes once the line has stayed high for a full idle character time (10 bit times with 8 data bits, 11 with 9). In address-mark mode it wakes on a character whose most significant data bit is set. That character is delivered and flagged as an address.

Top module: `mdrop_rx`

## Requirements
- R1: While hunting, a low sample starts a candidate start bit, and the oversample ticks of the cell are numbered from 0 at that sample. The start bit is confirmed by the majority of the samples at ticks 7, 8 and 9. If that majority is high, the receiver returns to hunting and produces no output.
- R2: Data bits arrive least significant bit first. With nine_bit=0, eight bits are received into data_out[7:0] and data_out[8] reads 0. With nine_bit=1, nine bits are received into data_out[8:0].
- R3: Each frame whose stop bit votes high, and which the sleep state allows, produces data_valid high for exactly one clock cycle.
- R4: A stop bit that votes low pulses frame_err for one cycle and produces no data_valid, whether the receiver is asleep or awake.
- R5: break_flag pulses together with frame_err when every received data bit of that frame is 0.
- R6: sleep_req high at a clock edge makes asleep read 1 after that edge.
- R7: While asleep, no data_valid is produced, except for an address character when wake_addr=1.
- R8: With wake_addr=1, the most significant data bit is data_out[7] when nine_bit=0 and data_out[8] when nine_bit=1. A good character whose most significant data bit is 1 is delivered with data_is_addr=1. If it arrives while asleep, it also clears asleep.
- R9: idle_flag pulses once the line has been high for 10 whole bit times (nine_bit=0) or 11 whole bit times (nine_bit=1). Any low sample restarts the count. With wake_addr=0, this pulse clears asleep.
- R10: idle_flag pulses at most once per idle period. The detector is armed out of reset and is armed again only by a completed frame.
- R11: When sleep_req coincides with a delivered character or a wake event, the character is still judged by the sleep state before that edge, and asleep reads 1 after the edge.
- R12: asleep is cleared only by the wake event of the selected method. An idle period does not wake the receiver when wake_addr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, high when idle |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_addr | input | 1 | 1 selects address-mark wake, 0 selects idle-line wake |
| sleep_req | input | 1 | Request to enter the sleep state |
| data_out | output | DATA_W+1 | Last received character |
| data_valid | output | 1 | One-cycle strobe for a delivered character |
| data_is_addr | output | 1 | Delivered character carries an address mark |
| asleep | output | 1 | Receiver is in the sleep state |
| idle_flag | output | 1 | One-cycle pulse when an idle period is detected |
| frame_err | output | 1 | One-cycle pulse for a low stop bit |
| break_flag | output | 1 | One-cycle pulse for an all-zero frame with a low stop bit |

## Verification
A sleep request can arrive in the very cycle in which a character is being delivered. That delivery may also be the address-mark wake-up of a sleeping receiver. The bench watches for data_valid at the falling edge and raises sleep_req in that same cycle. It does this once while awake and once while asleep with an address character. Both cases pass when the strobe was seen for that character and asleep afterwards reads 1, so the sleep request has won over the wake event.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
   import mdrop_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8,
   parameter bit VOTE3  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              nine_bit,
   output logic              chr_done,
   output logic [DATA_W:0]   chr_data,
   output logic              chr_msb,
   output logic              chr_ferr,
   output logic              chr_brk
);
   localparam int TW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W + 2);
   localparam logic [TW-1:0] T_A   = TW'(OVS/2 - 1);
   localparam logic [TW-1:0] T_B   = TW'(OVS/2);
   localparam logic [TW-1:0] T_C   = TW'(OVS/2 + 1);
   localparam logic [TW-1:0] T_END = TW'(OVS - 1);

   rx_state_e         st;
   logic [TW-1:0]     tcnt;
   logic [BW-1:0]     bcnt, nbits_q;
   logic              s_a, s_b, bit_v;
   logic [DATA_W:0]   sh, word;

   generate
      if (VOTE3) begin : g_vote3
         assign bit_v = maj3(s_a, s_b, rx_s);
      end else begin : g_vote1
         assign bit_v = s_b;
      end
   endgenerate

   assign word = (nbits_q == BW'(DATA_W + 1)) ? sh : {1'b0, sh[DATA_W:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_HUNT;
         tcnt     <= '0;
         bcnt     <= '0;
         nbits_q  <= BW'(DATA_W);
         s_a      <= 1'b1;
         s_b      <= 1'b1;
         sh       <= '0;
         chr_done <= 1'b0;
         chr_data <= '0;
         chr_msb  <= 1'b0;
         chr_ferr <= 1'b0;
         chr_brk  <= 1'b0;
      end else begin
         chr_done <= 1'b0;
         if (tick) begin
            if (st == ST_HUNT) begin
               if (!rx_s) begin
                  st      <= ST_START;
                  tcnt    <= TW'(1);
                  bcnt    <= '0;
                  nbits_q <= nine_bit ? BW'(DATA_W + 1) : BW'(DATA_W);
               end
            end else begin
               tcnt <= tcnt + 1'b1;
               if (tcnt == T_A) s_a <= rx_s;
               if (tcnt == T_B) s_b <= rx_s;
               if (tcnt == T_C) begin
                  case (st)
                     ST_START: if (bit_v) st <= ST_HUNT;
                     ST_DATA: begin
                        sh   <= {bit_v, sh[DATA_W:1]};
                        bcnt <= bcnt + 1'b1;
                     end
                     ST_STOP: begin
                        chr_done <= 1'b1;
                        chr_data <= word;
                        chr_msb  <= sh[DATA_W];
                        chr_ferr <= !bit_v;
                        chr_brk  <= !bit_v && (word == '0);
                        st       <= ST_HUNT;
                     end
                     default: ;
                  endcase
               end
               if (tcnt == T_END) begin
                  case (st)
                     ST_START: st <= ST_DATA;
                     ST_DATA:  if (bcnt == nbits_q) st <= ST_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   // R3: a character completion is a single-cycle event
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      chr_done |=> !chr_done);

   // R2: the stop cell is entered only after the selected number of data bits
   a_r2_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_DATA && st == ST_STOP) |-> (bcnt == nbits_q));

   // R1: a frame can only complete from a confirmed start
   a_r1_start_leaves_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_HUNT && st != ST_HUNT) |-> (st == ST_START));
endmodule

// File: rtl/mdrop_rx_idle.sv
module mdrop_rx_idle #(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_s,
   input  logic nine_bit,
   input  logic rearm,
   output logic idle_pulse
);
   localparam int TW = $clog2(OVS);
   localparam int IW = $clog2(DATA_W + 4);
   localparam logic [TW-1:0] T_END = TW'(OVS - 1);

   logic [TW-1:0] cnt;
   logic [IW-1:0] bits, need;
   logic          armed;

   assign need = nine_bit ? IW'(DATA_W + 3) : IW'(DATA_W + 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         bits       <= '0;
         armed      <= 1'b1;
         idle_pulse <= 1'b0;
      end else begin
         idle_pulse <= 1'b0;
         if (rearm) armed <= 1'b1;
         if (tick) begin
            if (!rx_s) begin
               cnt  <= '0;
               bits <= '0;
            end else begin
               cnt <= cnt + 1'b1;
               if (cnt == T_END) begin
                  if (bits < need) bits <= bits + 1'b1;
                  if (bits == need - 1'b1 && armed) begin
                     idle_pulse <= 1'b1;
                     armed      <= 1'b0;
                  end
               end
            end
         end
      end
   end

   // R10: one pulse per idle period
   a_r10_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |=> !idle_pulse);

   // R9: idle is only reported while the line is high
   a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> $past(rx_s));
endmodule

// File: rtl/mdrop_rx_wake.sv
module mdrop_rx_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_addr,
   input  logic sleep_req,
   input  logic chr_done,
   input  logic chr_ferr,
   input  logic chr_msb,
   input  logic idle_pulse,
   output logic asleep,
   output logic deliver,
   output logic addr_hit
);
   logic wake_ev;

   assign addr_hit = wake_addr & chr_msb;
   assign deliver  = chr_done & !chr_ferr & (!asleep | addr_hit);
   assign wake_ev  = asleep & (wake_addr ? deliver : idle_pulse);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         asleep <= 1'b0;
      else if (sleep_req) asleep <= 1'b1;
      else if (wake_ev)   asleep <= 1'b0;
   end

   // R6 / R11: a sleep request always wins at its edge
   a_r6_sleep_enter: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> asleep);

   // R7: nothing but an address mark is delivered while asleep
   a_r7_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && deliver) |-> (wake_addr && chr_msb));

   // R8: an address character wakes a sleeping receiver
   a_r8_addr_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && deliver && !sleep_req) |=> !asleep);

   // R9: an idle period wakes a sleeping receiver in idle-line mode
   a_r9_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !wake_addr && idle_pulse && !sleep_req) |=> !asleep);

   // R12: sleep ends only on a wake event
   a_r12_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> $past(deliver || idle_pulse));
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
   parameter int OVS      = 16,
   parameter int DATA_W   = 8,
   parameter int SYNC_STG = 2,
   parameter bit VOTE3    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              os_tick,
   input  logic              nine_bit,
   input  logic              wake_addr,
   input  logic              sleep_req,
   output logic [DATA_W:0]   data_out,
   output logic              data_valid,
   output logic              data_is_addr,
   output logic              asleep,
   output logic              idle_flag,
   output logic              frame_err,
   output logic              break_flag
);
   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("mdrop_rx: OVS must be a power of two and at least 8");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("mdrop_rx: DATA_W must be at least 2");
      end
      if (SYNC_STG < 1) begin : g_bad_sync
         $error("mdrop_rx: SYNC_STG must be at least 1");
      end
   endgenerate

   logic rx_s;
   logic chr_done, chr_msb, chr_ferr, chr_brk;
   logic idle_pulse, deliver, addr_hit;

   mdrop_rx_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s));

   mdrop_rx_frame #(.OVS(OVS), .DATA_W(DATA_W), .VOTE3(VOTE3)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .nine_bit(nine_bit),
      .chr_done(chr_done), .chr_data(data_out), .chr_msb(chr_msb),
      .chr_ferr(chr_ferr), .chr_brk(chr_brk));

   mdrop_rx_idle #(.OVS(OVS), .DATA_W(DATA_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .nine_bit(nine_bit),
      .rearm(chr_done), .idle_pulse(idle_pulse));

   mdrop_rx_wake u_wake (
      .clk(clk), .rst_n(rst_n), .wake_addr(wake_addr), .sleep_req(sleep_req),
      .chr_done(chr_done), .chr_ferr(chr_ferr), .chr_msb(chr_msb),
      .idle_pulse(idle_pulse), .asleep(asleep), .deliver(deliver), .addr_hit(addr_hit));

   assign data_valid   = deliver;
   assign data_is_addr = deliver & addr_hit;
   assign idle_flag    = idle_pulse;
   assign frame_err    = chr_done & chr_ferr;
   assign break_flag   = chr_done & chr_brk;

   // R4: a framing error never comes with a data strobe
   a_r4_ferr_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !data_valid);

   // R5: a break is a framing error on an all-zero character
   a_r5_break_is_ferr: assert property (@(posedge clk) disable iff (!rst_n)
      break_flag |-> (frame_err && data_out == '0));
endmodule

// File: tb/sim_mdrop_rx.sv
module sim_mdrop_rx;
   localparam int DW = 8;

   logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, os_tick = 1'b1;
   logic nine_bit = 1'b0, wake_addr = 1'b1, sleep_req = 1'b0;
   logic [DW:0] data_out;
   logic data_valid, data_is_addr, asleep, idle_flag, frame_err, break_flag;

   always #5 clk = ~clk;

   mdrop_rx #(.DATA_W(DW)) u0 (.*);

   int n_chk = 0, n_bad = 0;
   int n_val = 0, n_fe = 0, n_brk = 0, n_idle = 0;
   logic [DW:0] last_d = '0;
   logic last_a = 1'b0;

   always @(negedge clk) if (rst_n) begin
      if (data_valid) begin n_val++; last_d = data_out; last_a = data_is_addr; end
      if (frame_err)  n_fe++;
      if (break_flag) n_brk++;
      if (idle_flag)  n_idle++;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic bitcell(input logic v);
      rx_line = v;
      repeat (16) @(negedge clk);
   endtask

   task automatic send(input logic nine, input logic [8:0] d, input logic stop, input int gap);
      nine_bit = nine;
      bitcell(1'b0);
      for (int i = 0; i < (nine ? 9 : 8); i++) bitcell(d[i]);
      bitcell(stop);
      rx_line = 1'b1;
      repeat (gap * 16) @(negedge clk);
   endtask

   // {nine_bit, stop level, data}
   localparam logic [10:0] VEC [10] = '{
      {1'b0, 1'b1, 9'h055}, {1'b0, 1'b1, 9'h1A3}, {1'b0, 1'b1, 9'h000},
      {1'b0, 1'b1, 9'h0FF}, {1'b1, 1'b1, 9'h1A5}, {1'b1, 1'b1, 9'h0FF},
      {1'b1, 1'b1, 9'h100}, {1'b0, 1'b0, 9'h03C}, {1'b0, 1'b0, 9'h000},
      {1'b1, 1'b0, 9'h000}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v0, f0, b0, i0;
      logic seen_v, seen_a;
      repeat (5) @(negedge clk);
      check("R3 reset data_valid", data_valid, 0);
      check("R6 reset asleep", asleep, 0);
      rst_n = 1'b1;

      // idle after reset (armed out of reset)
      repeat (145) @(negedge clk);
      check("R9 no idle before 10 bit times", n_idle, 0);
      repeat (30) @(negedge clk);
      check("R9 idle after 10 bit times", n_idle, 1);
      repeat (300) @(negedge clk);
      check("R10 single idle pulse", n_idle, 1);

      // vector table
      for (int k = 0; k < 10; k++) begin
         logic nine, stop;
         logic [8:0] d, exp_d;
         nine = VEC[k][10]; stop = VEC[k][9]; d = VEC[k][8:0];
         exp_d = nine ? d : {1'b0, d[7:0]};
         v0 = n_val; f0 = n_fe; b0 = n_brk;
         send(nine, d, stop, 3);
         check("R3 valid pulses", n_val - v0, stop ? 1 : 0);
         if (stop) check("R2 data value", int'(last_d), int'(exp_d));
         check("R4 frame_err", n_fe - f0, stop ? 0 : 1);
         check("R5 break_flag", n_brk - b0, (!stop && exp_d == 0) ? 1 : 0);
      end

      // short low glitch is rejected
      v0 = n_val; f0 = n_fe;
      rx_line = 1'b0; repeat (8) @(negedge clk);
      rx_line = 1'b1; repeat (240) @(negedge clk);
      check("R1 glitch no data", n_val - v0, 0);
      check("R1 glitch no ferr", n_fe - f0, 0);
      // low covering samples 7..9 confirms a start; the rest reads as ones
      nine_bit = 1'b0;
      rx_line = 1'b0; repeat (10) @(negedge clk);
      rx_line = 1'b1; repeat (200) @(negedge clk);
      check("R1 confirmed start delivers", n_val - v0, 1);
      check("R1 confirmed start data", int'(last_d), 'h0FF);

      // 9-bit idle length
      i0 = n_idle;
      send(1'b1, 9'h055, 1'b1, 0);
      repeat (150) @(negedge clk);
      check("R9 no idle before 11 bit times", n_idle - i0, 0);
      repeat (20) @(negedge clk);
      check("R9 idle after 11 bit times", n_idle - i0, 1);

      // address-mark wake, 8 bit
      wake_addr = 1'b1;
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
      check("R6 asleep after request", asleep, 1);
      v0 = n_val;
      send(1'b0, 9'h035, 1'b1, 3);
      check("R7 data char suppressed", n_val - v0, 0);
      repeat (200) @(negedge clk);
      check("R12 idle ignored in address mode", asleep, 1);
      send(1'b0, 9'h085, 1'b1, 3);
      check("R8 address delivered", n_val - v0, 1);
      check("R8 address value", int'(last_d), 'h085);
      check("R8 address mark", last_a, 1);
      check("R8 woke", asleep, 0);
      send(1'b0, 9'h012, 1'b1, 3);
      check("R8 awake data no mark", last_a, 0);
      check("R8 awake data delivered", n_val - v0, 2);

      // address-mark wake, 9 bit
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
      v0 = n_val;
      send(1'b1, 9'h0FF, 1'b1, 3);
      check("R7 9-bit data suppressed", n_val - v0, 0);
      send(1'b1, 9'h101, 1'b1, 3);
      check("R8 9-bit address value", int'(last_d), 'h101);
      check("R8 9-bit woke", asleep, 0);

      // idle-line wake
      wake_addr = 1'b0; nine_bit = 1'b0;
      send(1'b0, 9'h011, 1'b1, 3);
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
      v0 = n_val; f0 = n_fe; i0 = n_idle;
      send(1'b0, 9'h081, 1'b1, 3);
      check("R7 idle mode suppresses address", n_val - v0, 0);
      check("R12 still asleep before idle", asleep, 1);
      send(1'b0, 9'h044, 1'b0, 3);
      check("R4 ferr while asleep", n_fe - f0, 1);
      repeat (200) @(negedge clk);
      check("R9 idle woke receiver", asleep, 0);
      check("R10 one idle pulse", n_idle - i0, 1);

      // sleep request in the delivery cycle
      wake_addr = 1'b1;
      seen_v = 1'b0; seen_a = 1'b0;
      fork
         send(1'b0, 9'h022, 1'b1, 3);
         begin
            do @(negedge clk); while (!data_valid);
            seen_v = 1'b1; seen_a = data_is_addr;
            sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
         end
      join
      check("R11 awake char delivered", seen_v, 1);
      check("R11 asleep after coincident request", asleep, 1);
      seen_v = 1'b0; seen_a = 1'b0;
      fork
         send(1'b0, 9'h090, 1'b1, 3);
         begin
            do @(negedge clk); while (!data_valid);
            seen_v = 1'b1; seen_a = data_is_addr;
            sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
         end
      join
      check("R11 address delivered while asleep", seen_a, 1);
      check("R11 request beats wake", asleep, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule